// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block pushes a configuration image into a programmable device that is loaded over a slave-serial pin interface. It takes the image as a byte stream with valid, ready and last signals. It drives three pins to the device: an active-low program line, a configuration clock and a serial data line. It watches the device's INIT and DONE inputs. A start pulse runs the whole sequence. First the program line is pulsed low and the INIT handshake is run in both directions. Then input bytes are thrown away until a sync preamble of consecutive all-ones bytes appears. From that point the image is shifted out. At the end the block waits for DONE.

Each image bit uses a four-phase pin pattern, and data idles high between bits. Every handshake wait polls its input at a fixed interval and gives up after a bounded number of polls. Each of the three waits has its own error code. Once a run is over, the result stays on the status outputs until the next start pulse. The poll interval and the phase length are parameters counted in system clock cycles.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the program line, configuration clock and serial data are all high. busy, doneOk and inReady are 0, and errCode is 0.
- R2: A start pulse seen while idle or finished drives the program line low from the next cycle, raises busy and clears doneOk and errCode to 0. A start pulse seen while busy has no effect.
- R3: While the program line is low, INIT is sampled once every POLL_CYCLES cycles. The first sample that finds INIT low releases the program line (high) at that same edge. If INIT is still high at sample MAX_POLLS+1, the run ends with errCode 1 (INIT-low failure) and the program line high. The configuration clock stays high while the program line is low.
- R4: After the program line is released, INIT is polled the same way until it reads high. If INIT is still low at sample MAX_POLLS+1, the run ends with errCode 2 (INIT-high failure).
- R5: In the search stage inReady is 1 and every offered byte is taken. A byte other than 0xFF restarts the count of consecutive 0xFF bytes. When the PRE_LEN-th (default 4) consecutive 0xFF byte is taken, shifting begins, and the first bytes sent are those PRE_LEN 0xFF bytes.
- R6: Each bit occupies four phases of PHASE_CYCLES cycles each: (clock 0, data 1), (clock 0, data = bit), (clock 1, data = bit), (clock 1, data 1).
- R7: Bytes go out in stream order, most significant bit first, eight bits per byte. Between bytes, and in every non-shifting state, clock and data are high.
- R8: inReady is 1 only in the search stage and while waiting for the next byte after a byte has been shifted out. A byte is taken when inValid and inReady are both 1. The byte taken with inLast = 1 is the final one.
- R9: After the final byte, DONE is polled like INIT. If it reads high, doneOk becomes 1 with errCode 0. If it is still low at sample MAX_POLLS+1, errCode becomes 3 (DONE failure).
- R10: When busy falls, doneOk and errCode keep their values until the next accepted start. doneOk = 1 and a non-zero errCode never occur together.
- R11: If a byte with inLast = 1 is taken during the search before the preamble completes, no clock pulse is produced and the block goes straight to the DONE wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a load when not busy |
| inByte | input | BYTE_W | Image byte |
| inValid | input | 1 | inByte is valid |
| inLast | input | 1 | inByte is the final image byte |
| inReady | output | 1 | Block takes the offered byte |
| initIn | input | 1 | Device INIT status |
| doneIn | input | 1 | Device DONE status |
| progOut | output | 1 | Program line to the device, low = program |
| cfgClk | output | 1 | Configuration clock to the device |
| cfgData | output | 1 | Serial configuration data to the device |
| busy | output | 1 | A load is in progress |
| doneOk | output | 1 | Last load finished with DONE high |
| errCode | output | 2 | 0 none, 1 INIT-low, 2 INIT-high, 3 DONE timeout |

## Verification
The assertions check, on every cycle, properties of the pins and status lines that hold at any moment:
- data is high whenever the clock falls;
- data does not change on a rising clock;
- the clock stays high while the program line is low;
- ready and a low program line only occur while busy;
- status is clear during a run, is never both success and error, and holds after a run.

The exact poll instants, the retry count before each timeout, the preamble restart on a non-0xFF byte, the replay of the preamble bytes and the bit order can only be shown by the bench's scenarios. There a behavioural model predicts every pin against stalled init responses, a missing DONE, gapped streams and a stream that ends before any preamble.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PROGLOW  = 3'd1,
    ST_INITHI   = 3'd2,
    ST_SEARCH   = 3'd3,
    ST_LOAD     = 3'd4,
    ST_SHIFT    = 3'd5,
    ST_DONEWAIT = 3'd6,
    ST_FINISH   = 3'd7
  } ldState_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_INITLOW  = 2'd1,
    ERR_INITHIGH = 2'd2,
    ERR_DONE     = 2'd3
  } ldErr_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clrRun;     // restart the all-ones run count
    logic takeSearch; // a byte is taken during the search
    logic loadByte;   // load shift register from the stream
    logic loadOnes;   // load shift register with an all-ones byte
    logic shiftBit;   // advance to the next bit
    logic progLow;    // hold the program line low
    logic clkLow;     // hold the configuration clock low
    logic showBit;    // drive the current bit on the data line
  } ldStrobe_t;

endpackage

// File: rtl/cfgl_datapath.sv
module cfgl_datapath
  import cfgl_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strobe,
  input  logic [BYTE_W-1:0] inByte,
  output logic              preHit,
  output logic              progOut,
  output logic              cfgClk,
  output logic              cfgData
);

  logic [BYTE_W-1:0] shReg;
  logic              isOnes;

  assign isOnes = &inByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
    end else if (strobe.loadByte) begin
      shReg <= inByte;
    end else if (strobe.loadOnes) begin
      shReg <= '1;
    end else if (strobe.shiftBit) begin
      shReg <= {shReg[BYTE_W-2:0], 1'b1};
    end
  end

  generate
    if (PRE_LEN == 1) begin : g_singleOnes
      assign preHit = isOnes;
    end else begin : g_runCount
      localparam int RUN_W = $clog2(PRE_LEN);
      logic [RUN_W-1:0] runCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runCnt <= '0;
        end else if (strobe.clrRun) begin
          runCnt <= '0;
        end else if (strobe.takeSearch) begin
          if (!isOnes) begin
            runCnt <= '0;
          end else if (runCnt != RUN_W'(PRE_LEN - 1)) begin
            runCnt <= runCnt + 1'b1;
          end
        end
      end

      assign preHit = isOnes && (runCnt == RUN_W'(PRE_LEN - 1));
    end
  endgenerate

  always_comb begin
    progOut = ~strobe.progLow;
    cfgClk  = ~strobe.clkLow;
    cfgData = strobe.showBit ? shReg[BYTE_W-1] : 1'b1;
  end

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int PRE_LEN      = 4,
  parameter int PHASE_CYCLES = 4,
  parameter int POLL_CYCLES  = 100000,
  parameter int MAX_POLLS    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       initIn,
  input  logic       doneIn,
  input  logic       preHit,
  output ldStrobe_t  strobe,
  output logic       inReady,
  output logic       busy,
  output logic       doneOk,
  output logic [1:0] errCode
);

  localparam int TMR_TOP = (PHASE_CYCLES > POLL_CYCLES) ? PHASE_CYCLES : POLL_CYCLES;
  localparam int TMR_W   = $clog2(TMR_TOP + 1);
  localparam int POLLS_W = $clog2(MAX_POLLS + 1);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int PRE_W   = $clog2(PRE_LEN + 1);

  ldState_e          state;
  logic [TMR_W-1:0]  tmr;
  logic [POLLS_W-1:0] polls;
  logic [1:0]        phase;
  logic [BIT_W-1:0]  bitIdx;
  logic [PRE_W-1:0]  preLeft;
  logic              lastFlag;
  logic              doneOkR;
  ldErr_e            errR;

  logic     pollTick, pollMet, phaseEnd, byteLast, byteDone, idleLike;
  ldState_e pollNext;
  ldErr_e   failCode;

  assign pollTick = (tmr == TMR_W'(POLL_CYCLES - 1));
  assign phaseEnd = (tmr == TMR_W'(PHASE_CYCLES - 1));
  assign byteLast = (bitIdx == BIT_W'(BYTE_W - 1));
  assign byteDone = (state == ST_SHIFT) && phaseEnd && (phase == 2'd3) && byteLast;
  assign idleLike = (state == ST_IDLE) || (state == ST_FINISH);

  // what each poll stage waits for, where it goes and how it fails
  always_comb begin
    case (state)
      ST_PROGLOW: begin pollMet = !initIn; pollNext = ST_INITHI;  failCode = ERR_INITLOW;  end
      ST_INITHI:  begin pollMet = initIn;  pollNext = ST_SEARCH;  failCode = ERR_INITHIGH; end
      default:    begin pollMet = doneIn;  pollNext = ST_FINISH;  failCode = ERR_DONE;     end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      polls    <= '0;
      phase    <= '0;
      bitIdx   <= '0;
      preLeft  <= '0;
      lastFlag <= 1'b0;
      doneOkR  <= 1'b0;
      errR     <= ERR_NONE;
    end else begin
      case (state)
        ST_IDLE, ST_FINISH: begin
          if (start) begin
            state   <= ST_PROGLOW;
            tmr     <= '0;
            polls   <= '0;
            doneOkR <= 1'b0;
            errR    <= ERR_NONE;
          end
        end
        ST_PROGLOW, ST_INITHI, ST_DONEWAIT: begin
          if (pollTick) begin
            tmr <= '0;
            if (pollMet) begin
              state <= pollNext;
              polls <= '0;
              if (state == ST_DONEWAIT) doneOkR <= 1'b1;
            end else if (polls == POLLS_W'(MAX_POLLS)) begin
              state <= ST_FINISH;
              errR  <= failCode;
            end else begin
              polls <= polls + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (inValid) begin
            if (preHit) begin
              state    <= ST_SHIFT;
              tmr      <= '0;
              phase    <= '0;
              bitIdx   <= '0;
              preLeft  <= PRE_W'(PRE_LEN);
              lastFlag <= inLast;
            end else if (inLast) begin
              state <= ST_DONEWAIT;
              tmr   <= '0;
              polls <= '0;
            end
          end
        end
        ST_LOAD: begin
          if (inValid) begin
            state    <= ST_SHIFT;
            tmr      <= '0;
            phase    <= '0;
            bitIdx   <= '0;
            preLeft  <= '0;
            lastFlag <= inLast;
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            tmr   <= '0;
            phase <= phase + 1'b1;
            if (phase == 2'd3) begin
              if (byteLast) begin
                bitIdx <= '0;
                if (preLeft > PRE_W'(1)) begin
                  preLeft <= preLeft - 1'b1;
                end else begin
                  preLeft <= '0;
                  polls   <= '0;
                  state   <= lastFlag ? ST_DONEWAIT : ST_LOAD;
                end
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clrRun     = idleLike && start;
    strobe.takeSearch = (state == ST_SEARCH) && inValid;
    strobe.loadByte   = (state == ST_LOAD) && inValid;
    strobe.loadOnes   = (strobe.takeSearch && preHit) || (byteDone && (preLeft > PRE_W'(1)));
    strobe.shiftBit   = (state == ST_SHIFT) && phaseEnd && (phase == 2'd3);
    strobe.progLow    = (state == ST_PROGLOW);
    strobe.clkLow     = (state == ST_SHIFT) && !phase[1];
    strobe.showBit    = (state == ST_SHIFT) && (phase[1] != phase[0]);
  end

  assign inReady = (state == ST_SEARCH) || (state == ST_LOAD);
  assign busy    = !idleLike;
  assign doneOk  = doneOkR;
  assign errCode = errR;

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int PRE_LEN      = 4,
  parameter int PHASE_CYCLES = 4,
  parameter int POLL_CYCLES  = 100000,
  parameter int MAX_POLLS    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  input  logic              initIn,
  input  logic              doneIn,
  output logic              progOut,
  output logic              cfgClk,
  output logic              cfgData,
  output logic              busy,
  output logic              doneOk,
  output logic [1:0]        errCode
);

  ldStrobe_t strobe;
  logic      preHit;

  cfgl_ctrl #(
    .BYTE_W      (BYTE_W),
    .PRE_LEN     (PRE_LEN),
    .PHASE_CYCLES(PHASE_CYCLES),
    .POLL_CYCLES (POLL_CYCLES),
    .MAX_POLLS   (MAX_POLLS)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .inValid(inValid),
    .inLast (inLast),
    .initIn (initIn),
    .doneIn (doneIn),
    .preHit (preHit),
    .strobe (strobe),
    .inReady(inReady),
    .busy   (busy),
    .doneOk (doneOk),
    .errCode(errCode)
  );

  cfgl_datapath #(
    .BYTE_W (BYTE_W),
    .PRE_LEN(PRE_LEN)
  ) i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inByte (inByte),
    .preHit (preHit),
    .progOut(progOut),
    .cfgClk (cfgClk),
    .cfgData(cfgData)
  );

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       inReady,
  input logic       progOut,
  input logic       cfgClk,
  input logic       cfgData,
  input logic       busy,
  input logic       doneOk,
  input logic [1:0] errCode
);

  a_r6_fall_data_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgClk) |-> cfgData);

  a_r6_rise_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  a_r3_prog_low_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    !progOut |-> cfgClk);

  a_r3_prog_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    !progOut |-> busy);

  a_r8_ready_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  a_r2_busy_clears_status: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (errCode == 2'd0 && !doneOk));

  a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && errCode != 2'd0));

  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(errCode) && $stable(doneOk)));

endmodule

bind cfg_serial_loader cfgl_checker i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .inReady(inReady),
  .progOut(progOut),
  .cfgClk (cfgClk),
  .cfgData(cfgData),
  .busy   (busy),
  .doneOk (doneOk),
  .errCode(errCode)
);

// File: tb/test_cfg_serial_loader.sv
`timescale 1ns/1ps
module test_cfg_serial_loader;

  localparam int PH   = 2;
  localparam int POLL = 4;
  localparam int MAXP = 3;
  localparam int PRE  = 4;
  localparam int WD   = 100000;

  typedef logic [7:0] byteQ_t[$];

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic inValid = 1'b0, inLast = 1'b0, initIn = 1'b1, doneIn = 1'b0;
  logic inReady, progOut, cfgClk, cfgData, busy, doneOk;
  logic [1:0] errCode;

  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  cfg_serial_loader #(
    .BYTE_W(8), .PRE_LEN(PRE), .PHASE_CYCLES(PH), .POLL_CYCLES(POLL), .MAX_POLLS(MAXP)
  ) i_cfg_serial_loader (
    .clk(clk), .rstN(rstN), .start(start), .inByte(inByte), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .initIn(initIn), .doneIn(doneIn),
    .progOut(progOut), .cfgClk(cfgClk), .cfgData(cfgData), .busy(busy),
    .doneOk(doneOk), .errCode(errCode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- stream feeder ----------------
  logic [7:0] feedQ[$];
  bit feedGap = 0, gapHold = 0, fireSeen = 0;
  always @(posedge clk) fireSeen <= inValid && inReady;
  always @(negedge clk) begin
    if (fireSeen && feedQ.size() > 0) begin
      void'(feedQ.pop_front());
      gapHold = feedGap;
    end else begin
      gapHold = 0;
    end
    if (feedQ.size() > 0 && !gapHold) begin
      inValid = 1; inByte = feedQ[0]; inLast = (feedQ.size() == 1);
    end else begin
      inValid = 0; inLast = 0;
    end
  end

  // ---------------- device responder ----------------
  bit stuckHigh = 0, stuckLow = 0, doneGood = 0;
  int loCnt = 0, hiCnt = 0, quiet = 0;
  always @(negedge clk) begin
    if (!progOut) begin
      hiCnt = 0;
      if (loCnt < 100) loCnt++;
      if (!stuckHigh && loCnt >= 6) initIn = 0;
    end else begin
      loCnt = 0;
      if (!initIn) begin
        hiCnt++;
        if (!stuckLow && hiCnt >= 5) initIn = 1;
      end
    end
    if (!cfgClk || inReady) quiet = 0; else if (quiet < 1000) quiet++;
    doneIn = doneGood && quiet >= 7;
  end

  // ---------------- capture of shifted bytes ----------------
  logic [7:0] capQ[$];
  logic [7:0] bitAcc = 8'h00;
  int nb = 0;
  always @(posedge cfgClk) begin
    if (rstN && busy) begin
      bitAcc = {bitAcc[6:0], cfgData};
      nb++;
      if (nb == 8) begin capQ.push_back(bitAcc); nb = 0; end
    end
  end

  // ---------------- behavioural reference model ----------------
  logic expProg = 1, expClk = 1, expData = 1, expReady = 0, expBusy = 0, expDoneOk = 0;
  logic [1:0] expErr = 0;

  task automatic mPoll(input int which, output bit ok);
    ok = 0;
    for (int n = 1; n <= MAXP + 1; n++) begin
      repeat (POLL) @(posedge clk);
      if ((which == 0 && !initIn) || (which == 1 && initIn) || (which == 2 && doneIn)) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic mSendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      expClk = 0; expData = 1;    repeat (PH) @(posedge clk);
      expData = b[i];             repeat (PH) @(posedge clk);
      expClk = 1;                 repeat (PH) @(posedge clk);
      expData = 1;                repeat (PH) @(posedge clk);
    end
  endtask

  task automatic modelRun();
    bit ok, found, lastAfter;
    int run;
    logic [7:0] b;
    expBusy = 1; expDoneOk = 0; expErr = 0; expProg = 0;
    mPoll(0, ok);
    expProg = 1;
    if (!ok) begin expErr = 1; expBusy = 0; return; end
    mPoll(1, ok);
    if (!ok) begin expErr = 2; expBusy = 0; return; end
    expReady = 1; run = 0; found = 0; lastAfter = 0;
    forever begin
      @(posedge clk);
      if (inValid) begin
        if (inByte == 8'hFF) run++; else run = 0;
        if (run == PRE) begin found = 1; lastAfter = inLast; break; end
        if (inLast) break;
      end
    end
    expReady = 0;
    if (found) begin
      repeat (PRE) mSendByte(8'hFF);
      while (!lastAfter) begin
        expReady = 1;
        do @(posedge clk); while (!inValid);
        b = inByte; lastAfter = inLast; expReady = 0;
        mSendByte(b);
      end
    end
    mPoll(2, ok);
    if (ok) expDoneOk = 1; else expErr = 3;
    expBusy = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rstN && start && !expBusy) modelRun();
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    chk(progOut === expProg, "R3 progOut", progOut, expProg);
    chk(cfgClk === expClk, "R6 cfgClk", cfgClk, expClk);
    chk(cfgData === expData, "R6 cfgData", cfgData, expData);
    chk(inReady === expReady, "R8 inReady", inReady, expReady);
    chk(busy === expBusy, "R2 busy", busy, expBusy);
    chk(doneOk === expDoneOk, "R10 doneOk", doneOk, expDoneOk);
    chk(errCode === expErr, "R10 errCode", errCode, expErr);
  end

  // ---------------- scenarios ----------------
  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic scenario(input string tag, input byteQ_t bytes, input bit gap,
                          input bit iHi, input bit iLo, input bit dGood,
                          input logic [1:0] wantErr, input bit wantOk,
                          input byteQ_t wantBytes, input bit poke);
    int guard;
    @(negedge clk);
    feedQ = bytes; feedGap = gap; stuckHigh = iHi; stuckLow = iLo; doneGood = dGood;
    initIn = 1; capQ.delete(); nb = 0;
    pulseStart();
    @(negedge clk);
    chk(busy === 1'b1 && errCode === 2'd0 && doneOk === 1'b0, "R2 start clears status",
        {busy, doneOk, errCode}, 4'b1000);
    if (poke) begin
      repeat (3) @(negedge clk);
      pulseStart();
      chk(busy === 1'b1, "R2 start while busy ignored", busy, 1);
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    chk(errCode === wantErr, {tag, " errCode"}, errCode, wantErr);
    chk(doneOk === wantOk, "R9 doneOk", doneOk, wantOk);
    chk(capQ.size() == wantBytes.size(), "R5 shifted byte count", capQ.size(), wantBytes.size());
    for (int k = 0; k < wantBytes.size() && k < capQ.size(); k++)
      chk(capQ[k] === wantBytes[k], "R7 shifted byte value", capQ[k], wantBytes[k]);
    repeat (20) @(negedge clk);
    chk(errCode === wantErr && doneOk === wantOk, "R10 status held", errCode, wantErr);
    feedQ.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(progOut && cfgClk && cfgData && !busy && !doneOk && errCode == 0 && !inReady,
        "R1 reset state", {progOut, cfgClk, cfgData, busy, doneOk, inReady}, 6'b111000);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R5 R7: restart of run on non-ones byte, preamble replay, MSB first
    scenario("R9 success", '{8'h12, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hA5, 8'h3C},
             0, 0, 0, 1, 2'd0, 1, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hA5, 8'h3C}, 0);
    // R3: INIT never falls, extra start while busy
    scenario("R3 init-low timeout", '{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 0, 1, 0, 1, 2'd1, 0, '{}, 1);
    // R4: INIT never comes back
    scenario("R4 init-high timeout", '{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 0, 0, 1, 1, 2'd2, 0, '{}, 0);
    // R9: DONE never rises, gapped stream
    scenario("R9 done timeout", '{8'h5A, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h01},
             1, 0, 0, 0, 2'd3, 0, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h01}, 0);
    // R8: fifth ones byte is data, gapped
    scenario("R8 extra ones byte", '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h81},
             1, 0, 0, 1, 2'd0, 1, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h81}, 0);
    // R11: stream ends during the search
    scenario("R11 no preamble", '{8'h00, 8'hFF, 8'h7E}, 0, 0, 0, 1, 2'd0, 1, '{}, 0);
    // R5: preamble completed by the last byte
    scenario("R5 preamble last", '{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 0, 0, 0, 1, 2'd0, 1,
             '{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R2: actual busy %0d expected run to end", busy);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule